// File: doc/BRIEF.md
# Channel Activity Cycle Counters

This block keeps four 32-bit counters that show how a radio channel is being used. One counts every clock. The other three count the clocks on which the receiver senses the channel busy, the clocks on which a frame is being received, and the clocks on which a frame is being transmitted. The receiver and the transmitter supply these three status inputs as per-cycle level signals. Software reaches the counters through a plain 32-bit register read/write port.

A single freeze bit in the control register stops all four counters in the same cycle, so they always form one consistent snapshot. The expected routine is: set freeze, read all four counters, write zero to each one, then write the control register back to zero. No event can fall between the reads and the clears. Software then derives idle listen time as total minus receive-frame minus transmit-frame cycles. That difference only means something if the counters were stopped together.

The counters saturate instead of wrapping. A sticky overflow flag shows that at least one event was lost at saturation.

Top module: `chan_cycle_counters`

## Requirements
- R1: After reset every counter reads zero, the control register reads zero (freeze clear, overflow clear) and rvalid_o is low.
- R2: While freeze is clear, the total counter (address 1) increments on every clock.
- R3: While freeze is clear, the busy counter (address 2), the receive-frame counter (address 3) and the transmit-frame counter (address 4) increment on each clock where rx_busy_i, rx_frame_i and tx_frame_i respectively is high.
- R4: Control bit 0 (freeze), when set, stops all four counters from the clock edge after the write. Writing the control register with bit 0 clear resumes counting from the edge after that write.
- R5: A write to a counter address loads wdata_i into that counter, so a zero write clears it. The load takes priority over an increment in the same cycle.
- R6: A counter holding all ones stays at all ones when further events arrive.
- R7: Control bit 1 (overflow) becomes 1 on the edge where any counter gets an event while holding all ones. It then stays set until a control write with bit 1 set clears it. A set in the same cycle as a clear wins.
- R8: A read request (rd_en_i) returns on rdata_o one cycle later, with rvalid_o high for exactly that cycle. The value is the register content from before the request edge. The control register reads as {30'b0, overflow, freeze}.
- R9: Addresses 5 to 7 read as zero, and writes to them change no counter and no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| rvalid_o | output | 1 | Read data valid |
| rx_busy_i | input | 1 | Receive channel sensed busy this cycle |
| rx_frame_i | input | 1 | Frame reception in progress this cycle |
| tx_frame_i | input | 1 | Frame transmission in progress this cycle |

## Verification
The bench sweeps eight status-input patterns of different lengths between an unfreeze and a freeze. It expects the total counter to read exactly one more than the pattern length. An off-by-one freeze or unfreeze edge shows up as a total that is one too high or one too low. The same applies to an input sampled one cycle late, which would count events from the clock next to the window.

Counters preset just below all ones must stop at all ones and raise the overflow flag. A wrapping counter would read a small value instead, and a flag that is not sticky would read zero.

Freeze must hold every counter against inputs held high. Writes to unmapped addresses must disturb nothing. The read of total taken right after reset must return zero; a read path that returns the post-edge value would show one.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned NUM_CNT = 4;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 32;
  localparam int unsigned FRZ_BIT = 0;
  localparam int unsigned OVF_BIT = 1;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 3'd0,
    A_TOTAL = 3'd1,
    A_BUSY  = 3'd2,
    A_RXF   = 3'd3,
    A_TXF   = 3'd4
  } cc_addr_e;
endpackage

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         ev_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         lost_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;
  logic         bump;

  assign bump = run_i & ev_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (ld_i)                    cnt_q <= ld_val_i;
    else if (bump && cnt_q != MAX)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign lost_o = bump & ~ld_i & (cnt_q == MAX);

  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ev_i && !ld_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_frozen_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_i) |=> $stable(cnt_q));
  p_load_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i));
  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !ld_i) |=> cnt_q == MAX);
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic frz_val_i,
  input  logic ovf_clr_i,
  input  logic lost_i,
  output logic frz_o,
  output logic ovf_o
);
  logic frz_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_i) frz_q <= frz_val_i;
      // set beats clear
      if (lost_i)                 ovf_q <= 1'b1;
      else if (wr_i && ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign frz_o = frz_q;
  assign ovf_o = ovf_q;

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_i && ovf_clr_i)) |=> ovf_q);
  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |=> ovf_q);
  p_frz_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(frz_q));
endmodule

// File: rtl/chan_cycle_counters.sv
module chan_cycle_counters
  import cc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  input  logic          rx_busy_i,
  input  logic          rx_frame_i,
  input  logic          tx_frame_i
);
  localparam int unsigned FIRST_CNT = int'(A_TOTAL);

  logic [NUM_CNT-1:0]            ev;
  logic [NUM_CNT-1:0]            lost;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic                          frz, ovf, ctrl_wr;
  logic [DW-1:0]                 rd_mux, rdata_q;
  logic                          rvalid_q;

  assign ev      = {tx_frame_i, rx_frame_i, rx_busy_i, 1'b1};
  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);

  cc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .frz_val_i (wdata_i[FRZ_BIT]),
    .ovf_clr_i (wdata_i[OVF_BIT]),
    .lost_i    (|lost),
    .frz_o     (frz),
    .ovf_o     (ovf)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic ld;
    assign ld = wr_en_i && (addr_i == AW'(FIRST_CNT + i));
    cc_counter #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (~frz),
      .ev_i     (ev[i]),
      .ld_i     (ld),
      .ld_val_i (wdata_i[CNT_W-1:0]),
      .cnt_o    (cnt[i]),
      .lost_o   (lost[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_CTRL) begin
      rd_mux[FRZ_BIT] = frz;
      rd_mux[OVF_BIT] = ovf;
    end else if (addr_i >= A_TOTAL && addr_i <= A_TXF) begin
      rd_mux = DW'(cnt[addr_i - A_TOTAL]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_rvalid_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  p_total_runs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frz && !wr_en_i && cnt[0] != '1) |=> cnt[0] == $past(cnt[0]) + 1'b1);
  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > A_TXF && frz) |=> $stable(cnt) && $stable(ovf) && frz);
endmodule

// File: tb/test_chan_cycle_counters.sv
module test_chan_cycle_counters;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd1;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        rx_busy_i = 1'b0, rx_frame_i = 1'b0, tx_frame_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #10 clk_i = ~clk_i;

  chan_cycle_counters i_chan_cycle_counters (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0;
    chk("R8 rvalid", {31'b0, rvalid_o}, 32'd1);
    d = rdata_o;
  endtask

  task automatic set_in(logic b, logic r, logic t);
    rx_busy_i = b; rx_frame_i = r; tx_frame_i = t;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: read of total set up before reset release
    rd_en_i = 1'b1; addr_i = 3'd1;
    #25;
    chk("R1 rvalid in reset", {31'b0, rvalid_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0;
    chk("R1 total at reset", rdata_o, 32'd0);
    @(negedge clk_i);
    chk("R8 rvalid drops", {31'b0, rvalid_o}, 32'd0);
    rd(3'd0, rv); chk("R1 ctrl at reset", rv, 32'd0);
    for (int a = 2; a <= 4; a++) begin
      rd(3'(a), rv); chk("R1 event counter at reset", rv, 32'd0);
    end

    // R2 R3 R4: pattern sweep
    for (int p = 0; p < 8; p++) begin
      int n, eb, er, et;
      n = 17 + p * 5; eb = 0; er = 0; et = 0;
      wr(3'd0, 32'd1);
      for (int a = 1; a <= 4; a++) wr(3'(a), 32'd0);
      wr(3'd0, 32'd0);
      for (int i = 0; i < n; i++) begin
        logic [7:0] h;
        h = 8'(i * 37 + p * 11 + p * i);
        set_in(h[0] ^ h[3], h[1] | (p[0] & h[5]), h[2] & (h[4] | p[1]));
        eb += int'(rx_busy_i); er += int'(rx_frame_i); et += int'(tx_frame_i);
        @(posedge clk_i); @(negedge clk_i);
      end
      set_in(1'b0, 1'b0, 1'b0);
      wr(3'd0, 32'd1);
      rd(3'd1, rv); chk("R2 total cycles", rv, 32'(n + 1));
      rd(3'd2, rv); chk("R3 busy cycles", rv, 32'(eb));
      rd(3'd3, rv); chk("R3 rx frame cycles", rv, 32'(er));
      rd(3'd4, rv); chk("R3 tx frame cycles", rv, 32'(et));
      rd(3'd0, rv); chk("R4 freeze readback", rv, 32'd1);
    end

    // R4: frozen counters ignore busy inputs
    set_in(1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk_i);
    rd(3'd1, rv); chk("R4 frozen total", rv, 32'd53);
    set_in(1'b0, 1'b0, 1'b0);

    // R5: load values
    wr(3'd2, 32'hA5A5_0001);
    rd(3'd2, rv); chk("R5 load busy", rv, 32'hA5A5_0001);
    wr(3'd4, 32'h0000_0000);
    rd(3'd4, rv); chk("R5 clear tx", rv, 32'd0);

    // R9: unmapped writes ignored, reads zero
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1234_5678);
    rd(3'd2, rv); chk("R9 busy untouched", rv, 32'hA5A5_0001);
    rd(3'd0, rv); chk("R9 ctrl untouched", rv, 32'd1);
    rd(3'd6, rv); chk("R9 unmapped read", rv, 32'd0);

    // R6 R7: saturation and sticky overflow
    wr(3'd1, 32'hFFFF_FFFD);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd0);
    rd(3'd0, rv); chk("R7 no overflow yet", rv, 32'd1);
    wr(3'd0, 32'd0);
    set_in(1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk_i);
    set_in(1'b0, 1'b0, 1'b0);
    wr(3'd0, 32'd1);
    rd(3'd1, rv); chk("R6 total saturates", rv, 32'hFFFF_FFFF);
    rd(3'd2, rv); chk("R6 busy saturates", rv, 32'hFFFF_FFFF);
    rd(3'd3, rv); chk("R3 rx during saturation", rv, 32'd9);
    rd(3'd0, rv); chk("R7 overflow set", rv, 32'd3);
    repeat (3) @(negedge clk_i);
    rd(3'd0, rv); chk("R7 overflow sticky", rv, 32'd3);
    wr(3'd0, 32'd3);
    rd(3'd0, rv); chk("R7 overflow cleared", rv, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule